// File: doc/BRIEF.md
# Command Strobe and Keyed Reboot Controller

This block sits behind a simple register write port and turns software writes into control actions for the rest of the chip. A command register takes numeric codes that raise a single-cycle reset pulse or a reconfiguration request. A strobe register gives a one-cycle read request toward a data FIFO, and set/clear control of a persistent clock-switch output. It also drives a two-step synchronization sequence: software first arms it, then activates it.

Reconfiguration has a second path, a reboot register. A write there requests reconfiguration only when the written word is the bitwise inverse of the firmware revision word presented on an input. Once the synchronization sequence is armed and activated, it waits for a rising edge on any of 64 source inputs that a 64-bit mask enables. The mask is written through two 32-bit registers. The block only emits request and control signals. The reconfiguration engine and the clock hardware live elsewhere.

Top module: `cmdreboot_ctrl`

## Requirements
- R1: A write of the value 1 to the command register (address 0) makes `rst_pulse` high for exactly the cycle after the write edge. Writes of 0 or of any value other than 1 and 2 raise no pulse.
- R2: A write of the value 2 to the command register makes `reconf_req` high for exactly the cycle after the write edge.
- R3: A write to the reboot register (address 2) makes `reconf_req` high for one cycle only if the written word equals the bitwise inverse of `fw_revision`. Any other value has no effect.
- R4: Reading the command register always returns 0.
- R5: A write to the strobe register (address 1) with bit 2 set makes `fifo_rd_pulse` high for the one cycle after the write edge.
- R6: A strobe write with bit 4 set drives `clk_switch` to 1, and one with bit 3 set drives it to 0. When both bits are set, the clear wins. Otherwise the value persists.
- R7: In the idle state, a strobe write with bit 5 set arms the sequence, and `sync_armed` goes high after the write edge. A read of the strobe register returns `clk_switch` in bit 0, the armed flag in bit 1, the waiting flag in bit 2, and zeros elsewhere.
- R8: A strobe write with bit 6 set is ignored unless the sequence is already armed. If bits 5 and 6 arrive in the same write from idle, only the arm takes effect.
- R9: Bit 6 written while armed clears `sync_armed` and sets `sync_waiting`.
- R10: While waiting, the first cycle in which some source bit that is enabled in the mask is 1, after having been 0 the cycle before, raises `sync_pulse` for one cycle and returns the sequence to idle. Edges on masked-off sources, and edges outside the waiting state, do nothing.
- R11: The mask's low half is written and read at address 3, and its high half (sources 63..32) at address 4.
- R12: After synchronous reset, all outputs, the mask and the sequence state are 0 or idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| fw_revision | input | 32 | Firmware revision word, used to derive the reboot key |
| sync_src | input | 64 | Candidate synchronization sources, synchronous to clk |
| rst_pulse | output | 1 | One-cycle reset request |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| fifo_rd_pulse | output | 1 | One-cycle FIFO read request |
| clk_switch | output | 1 | Persistent clock-switch control |
| sync_armed | output | 1 | Sequence is armed |
| sync_waiting | output | 1 | Sequence is activated and waiting for a source edge |
| sync_pulse | output | 1 | One-cycle synchronization strobe |

## Verification
The bench probes the reboot key with a near-miss word and with the uninverted revision word. A design that compared against the plain revision, or only a few bits of it, would reboot on one of these. It writes set and clear together to the clock-switch bits, where a set-priority design would leave the output high. It also tries activation without an arm and arm-plus-activate in one write, and a design that skipped the arm check would start waiting. Finally, it raises source edges while idle, on masked-off bits, and on a source that is already high when the wait begins. A level-sensitive or unmasked design would fire early, and the bench catches that.

// File: rtl/cr_pkg.sv
package cr_pkg;

    // register map (word addresses)
    localparam int unsigned A_CMD     = 0;
    localparam int unsigned A_STROBE  = 1;
    localparam int unsigned A_REBOOT  = 2;
    localparam int unsigned A_MASK_LO = 3;
    localparam int unsigned A_MASK_HI = 4;

    // command codes
    localparam int unsigned CMD_RESET  = 1;
    localparam int unsigned CMD_RECONF = 2;

    // strobe register bit positions
    localparam int unsigned SB_FIFO_RD = 2;
    localparam int unsigned SB_SW_CLR  = 3;
    localparam int unsigned SB_SW_SET  = 4;
    localparam int unsigned SB_ARM     = 5;
    localparam int unsigned SB_FIRE    = 6;

    // status bit positions in the strobe read-back
    localparam int unsigned ST_SWITCH  = 0;
    localparam int unsigned ST_ARMED   = 1;
    localparam int unsigned ST_WAITING = 2;

    typedef enum logic [1:0] {
        SY_IDLE  = 2'd0,
        SY_ARMED = 2'd1,
        SY_WAIT  = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic rst;
        logic reconf;
        logic fifo_rd;
    } pulse_set_t;

endpackage

// File: rtl/cr_cmd_unit.sv
module cr_cmd_unit #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] fw_revision,
    output cr_pkg::pulse_set_t pulses,
    output logic          clk_switch
);
    import cr_pkg::*;

    localparam logic [AW-1:0] ADR_CMD    = AW'(A_CMD);
    localparam logic [AW-1:0] ADR_STROBE = AW'(A_STROBE);
    localparam logic [AW-1:0] ADR_REBOOT = AW'(A_REBOOT);
    localparam logic [DW-1:0] CODE_RST   = DW'(CMD_RESET);
    localparam logic [DW-1:0] CODE_RCF   = DW'(CMD_RECONF);

    logic       cmd_wr, strobe_wr, reboot_wr, key_ok;
    pulse_set_t nxt;

    always_comb begin
        cmd_wr     = wr_en && (wr_addr == ADR_CMD);
        strobe_wr  = wr_en && (wr_addr == ADR_STROBE);
        reboot_wr  = wr_en && (wr_addr == ADR_REBOOT);
        key_ok     = (wr_data ^ fw_revision) == '1;
        nxt.rst     = cmd_wr && (wr_data == CODE_RST);
        nxt.reconf  = (cmd_wr && (wr_data == CODE_RCF)) || (reboot_wr && key_ok);
        nxt.fifo_rd = strobe_wr && wr_data[SB_FIFO_RD];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses     <= '0;
            clk_switch <= 1'b0;
        end else begin
            pulses <= nxt;
            if (strobe_wr) begin
                if (wr_data[SB_SW_CLR])
                    clk_switch <= 1'b0;
                else if (wr_data[SB_SW_SET])
                    clk_switch <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cr_mask_regs.sv
module cr_mask_regs #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [2*DW-1:0] mask
);
    import cr_pkg::*;

    localparam int HALVES = 2;

    for (genvar g = 0; g < HALVES; g++) begin : g_half
        localparam logic [AW-1:0] ADR = AW'(A_MASK_LO + g);
        always_ff @(posedge clk) begin
            if (rst)
                mask[g*DW +: DW] <= '0;
            else if (wr_en && (wr_addr == ADR))
                mask[g*DW +: DW] <= wr_data;
        end
    end

endmodule

// File: rtl/cr_sync_unit.sv
module cr_sync_unit #(
    parameter int SW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          fire,
    input  logic [SW-1:0] mask,
    input  logic [SW-1:0] src,
    output logic          armed,
    output logic          waiting,
    output logic          pulse
);
    import cr_pkg::*;

    sync_state_e   state;
    logic [SW-1:0] src_q;
    logic          hit;

    assign hit     = |(src & ~src_q & mask);
    assign armed   = (state == SY_ARMED);
    assign waiting = (state == SY_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SY_IDLE;
            src_q <= '0;
            pulse <= 1'b0;
        end else begin
            src_q <= src;
            pulse <= 1'b0;
            unique case (state)
                SY_IDLE:  if (arm)  state <= SY_ARMED;
                SY_ARMED: if (fire) state <= SY_WAIT;
                SY_WAIT:  if (hit) begin
                    pulse <= 1'b1;
                    state <= SY_IDLE;
                end
                default:  state <= SY_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdreboot_ctrl.sv
module cmdreboot_ctrl #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [DW-1:0]   fw_revision,
    input  logic [2*DW-1:0] sync_src,
    output logic            rst_pulse,
    output logic            reconf_req,
    output logic            fifo_rd_pulse,
    output logic            clk_switch,
    output logic            sync_armed,
    output logic            sync_waiting,
    output logic            sync_pulse
);
    import cr_pkg::*;

    localparam int SW = 2 * DW;
    localparam logic [AW-1:0] ADR_STROBE  = AW'(A_STROBE);
    localparam logic [AW-1:0] ADR_MASK_LO = AW'(A_MASK_LO);
    localparam logic [AW-1:0] ADR_MASK_HI = AW'(A_MASK_HI);

    pulse_set_t    pulses;
    logic [SW-1:0] mask;
    logic          strobe_wr;

    cr_cmd_unit #(.DW(DW), .AW(AW)) u_cmd (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fw_revision(fw_revision),
        .pulses(pulses), .clk_switch(clk_switch)
    );

    cr_mask_regs #(.DW(DW), .AW(AW)) u_mask (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mask(mask)
    );

    assign strobe_wr = wr_en && (wr_addr == ADR_STROBE);

    cr_sync_unit #(.SW(SW)) u_sync (
        .clk(clk), .rst(rst),
        .arm(strobe_wr && wr_data[SB_ARM]),
        .fire(strobe_wr && wr_data[SB_FIRE]),
        .mask(mask), .src(sync_src),
        .armed(sync_armed), .waiting(sync_waiting), .pulse(sync_pulse)
    );

    assign rst_pulse     = pulses.rst;
    assign reconf_req    = pulses.reconf;
    assign fifo_rd_pulse = pulses.fifo_rd;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_STROBE: begin
                rd_data[ST_SWITCH]  = clk_switch;
                rd_data[ST_ARMED]   = sync_armed;
                rd_data[ST_WAITING] = sync_waiting;
            end
            ADR_MASK_LO: rd_data = mask[DW-1:0];
            ADR_MASK_HI: rd_data = mask[SW-1:DW];
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cr_checker.sv
module cr_checker #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic [AW-1:0] rd_addr,
    input logic [DW-1:0] rd_data,
    input logic [DW-1:0] fw_revision,
    input logic          rst_pulse,
    input logic          reconf_req,
    input logic          fifo_rd_pulse,
    input logic          clk_switch,
    input logic          sync_armed,
    input logic          sync_waiting,
    input logic          sync_pulse
);
    import cr_pkg::*;

    p_rst_cause_r1: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> $past(wr_en && wr_addr == AW'(A_CMD) && wr_data == DW'(CMD_RESET)));

    p_reconf_cause_r3: assert property (@(posedge clk) disable iff (rst)
        reconf_req |-> $past(wr_en && ((wr_addr == AW'(A_CMD) && wr_data == DW'(CMD_RECONF))
                             || (wr_addr == AW'(A_REBOOT) && wr_data == ~fw_revision))));

    p_cmd_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == AW'(A_CMD)) |-> (rd_data == '0));

    p_fifo_cause_r5: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_pulse |-> $past(wr_en && wr_addr == AW'(A_STROBE) && wr_data[SB_FIFO_RD]));

    p_clear_wins_r6: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && wr_addr == AW'(A_STROBE) && wr_data[SB_SW_CLR]) |-> !clk_switch);

    p_state_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(sync_armed && sync_waiting));

    p_wait_needs_arm_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_waiting) |-> $past(sync_armed));

    p_pulse_from_wait_r10: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> ($past(sync_waiting) && !sync_waiting));

endmodule

bind cmdreboot_ctrl cr_checker #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/cmdreboot_ctrl_test.sv
`timescale 1ns/1ps
module cmdreboot_ctrl_test;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam logic [DW-1:0] REV = 32'h5B6D_E806;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [DW-1:0]   fw_revision = REV;
    logic [2*DW-1:0] sync_src = '0;
    logic rst_pulse, reconf_req, fifo_rd_pulse, clk_switch;
    logic sync_armed, sync_waiting, sync_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cmdreboot_ctrl #(.DW(DW), .AW(AW)) uut (.*);

    // behavioural reference model
    bit        m_rst, m_rcf, m_fifo, m_sw, m_pulse;
    int        m_st;            // 0 idle, 1 armed, 2 waiting
    bit [63:0] m_mask, m_prev;
    int        sync_count = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_rst = 0; m_rcf = 0; m_fifo = 0; m_sw = 0; m_pulse = 0;
            m_st = 0; m_mask = 0; m_prev = 0;
        end else begin
            bit        wc, ws, wb;
            bit [63:0] rising;
            wc = wr_en && wr_addr == 0;
            ws = wr_en && wr_addr == 1;
            wb = wr_en && wr_addr == 2;
            rising = sync_src & ~m_prev & m_mask;
            m_rst  = wc && wr_data == 1;
            m_rcf  = (wc && wr_data == 2) || (wb && wr_data == ~fw_revision);
            m_fifo = ws && wr_data[2];
            if (ws && wr_data[3]) m_sw = 0;
            else if (ws && wr_data[4]) m_sw = 1;
            m_pulse = 0;
            if (m_st == 0) begin
                if (ws && wr_data[5]) m_st = 1;
            end else if (m_st == 1) begin
                if (ws && wr_data[6]) m_st = 2;
            end else if (rising != 0) begin
                m_pulse = 1; m_st = 0; sync_count++;
            end
            if (wr_en && wr_addr == 3) m_mask[31:0]  = wr_data;
            if (wr_en && wr_addr == 4) m_mask[63:32] = wr_data;
            m_prev = sync_src;
        end
    end

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        case (a)
            3'd1: return {29'd0, m_st == 2, m_st == 1, m_sw};
            3'd3: return m_mask[31:0];
            3'd4: return m_mask[63:32];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 rst_pulse", 64'(rst_pulse), 64'(m_rst));
        chk("R2/R3 reconf_req", 64'(reconf_req), 64'(m_rcf));
        chk("R5 fifo_rd_pulse", 64'(fifo_rd_pulse), 64'(m_fifo));
        chk("R6 clk_switch", 64'(clk_switch), 64'(m_sw));
        chk("R7 R8 sync_armed", 64'(sync_armed), 64'(m_st == 1));
        chk("R9 sync_waiting", 64'(sync_waiting), 64'(m_st == 2));
        chk("R10 sync_pulse", 64'(sync_pulse), 64'(m_pulse));
        if (rd_addr == 0) chk("R4 cmd readback", 64'(rd_data), 64'(0));
        else              chk("R11 R7 readback", 64'(rd_data), 64'(exp_rd(rd_addr)));
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
        rd_addr = (rd_addr >= 4) ? '0 : rd_addr + 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 reset outputs", {57'd0, rst_pulse, reconf_req, fifo_rd_pulse,
            clk_switch, sync_armed, sync_waiting, sync_pulse}, 64'd0);
        rd_addr = 3'd3;
        #0.1 chk("R12 reset mask", 64'(rd_data), 64'd0);
        rst = 0;
        rd_addr = '0;
        idle(2);
        // R1 / R2 command codes
        wr(3'd0, 32'd0); idle(1);
        wr(3'd0, 32'd1); idle(1);
        wr(3'd0, 32'd1); wr(3'd0, 32'd1); idle(1);
        wr(3'd0, 32'd2); idle(1);
        wr(3'd0, 32'd7); wr(3'd0, 32'h101); idle(2);
        // R3 reboot key
        wr(3'd2, REV); idle(1);
        wr(3'd2, ~REV ^ 32'h1); idle(1);
        wr(3'd2, ~REV ^ 32'h8000_0000); idle(1);
        wr(3'd2, ~REV); idle(2);
        // R5 fifo pulse
        wr(3'd1, 32'h4); wr(3'd1, 32'h0); idle(1);
        // R6 switch set / clear / both
        wr(3'd1, 32'h10); idle(2);
        wr(3'd1, 32'h4); idle(1);
        wr(3'd1, 32'h18); idle(1);
        wr(3'd1, 32'h10); wr(3'd1, 32'h08); idle(1);
        // R11 mask: low bit 3, high bit 5 (source 37)
        wr(3'd3, 32'h0000_0008); wr(3'd4, 32'h0000_0020); idle(5);
        // R8 fire without arm, and arm+fire from idle
        wr(3'd1, 32'h40); idle(1);
        sync_src = 64'h8; idle(2); sync_src = 0; idle(1);   // idle edge ignored (R10)
        wr(3'd1, 32'h60); idle(2);
        sync_src = 64'h8; idle(2); sync_src = 0; idle(1);   // armed only, no fire
        wr(3'd1, 32'h20); idle(1);                          // arm while armed: stays
        wr(3'd1, 32'h40); idle(1);                          // R9 now waiting
        sync_src = 64'h3; idle(2); sync_src = 0; idle(1);   // masked-off edges
        sync_src = 64'h20_0000_0000; idle(3);               // R10 fire on source 37
        chk("R10 fired once", 64'(sync_count), 64'd1);
        // source already high when wait starts: needs a fresh edge
        wr(3'd1, 32'h20); wr(3'd1, 32'h40); idle(3);
        chk("R10 no level fire", 64'(sync_count), 64'd1);
        sync_src = 0; idle(1);
        sync_src = 64'h8; idle(3);
        chk("R10 fired twice", 64'(sync_count), 64'd2);
        // both bits in one write while armed: fire wins, activation taken
        sync_src = 0;
        wr(3'd1, 32'h20); wr(3'd1, 32'h60); idle(1);
        wr(3'd1, 32'h50); idle(2);                          // switch set during wait
        sync_src = 64'h8; idle(3);
        chk("R10 fired thrice", 64'(sync_count), 64'd3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule